// File: doc/BRIEF.md
# Spread Spectrum Fine-Word Modulator

This block sits between the frequency controller of a digital frequency-locked oscillator and the oscillator's fine-tune input. While it is enabled, it adds a small signed offset to the fine-tune word. The offset moves the oscillator frequency back and forth around its nominal value. The clock energy is then spread over a band of frequencies instead of sitting on one line, which lowers the peak radiated emission.

The offset moves only on modulation ticks. A tick is a one-cycle enable pulse taken from a separate dither timebase. An optional pseudo-random qualifier lets only some of those ticks advance the offset, which blurs the tick rate in the output spectrum. Two waveforms are available:

- With an amplitude of zero, the block flips the least significant bit of the fine word.
- With a nonzero amplitude, the offset is a triangle whose step and peak are set by the step and amplitude fields.

The sum of the fine word and the offset saturates at the limits of the fine word. Each saturation is recorded in a sticky flag.

Top module: `ssg_fine_mod`

## Requirements
- R1: While `en` is 0, `fine_out` equals `fine_in`, and ticks have no effect on the output. Clearing `en` returns the internal offset to zero at the next clock edge.
- R2: The offset and the LSB toggle state change only at a clock edge where a qualified tick is present. With `tick` low, `fine_out` keeps its value for a constant `fine_in`.
- R3: The pseudo-random qualifier is a 15-bit LFSR.
  - It is seeded to 1 by reset.
  - It shifts left on every `tick`, whatever the state of `en`.
  - The new bit 0 is the XOR of bits 14 and 13.
  - When `prbs_sel` is 1, a tick is qualified only if bit 0 of the LFSR, as it was before that tick's shift, is 1.
  - When `prbs_sel` is 0, every tick is qualified.
- R4: With `amp` equal to 0, each qualified tick inverts a toggle bit. `fine_out` is `fine_in` XOR that bit, so only bit 0 of the fine word can change.
- R5: With `amp` nonzero, the offset starts at 0 going up and moves by the effective step on each qualified tick.
  - It turns downward on reaching +`amp`×step.
  - It turns upward on reaching −`amp`×step.
  - `fine_out` is `fine_in` plus the offset.
- R6: A `step` field of 0 or 1 gives an effective step of 1. Any other value n gives a step of n.
- R7: If `fine_in` plus the offset exceeds 1023, `fine_out` is 1023. `ovf` becomes 1 at the next clock edge and stays 1 after the excess has gone.
- R8: If `fine_in` plus the offset is below 0, `fine_out` is 0. `udf` becomes 1 at the next clock edge and stays 1.
- R9: A clock edge with `flag_clr` high clears `ovf` and `udf`, unless a new saturation is present in the same cycle. If so, the new saturation wins.
- R10: A clock edge at which `amp` or `step` differs from its value at the previous edge sets the offset to zero, the direction to up and the toggle bit to zero. Any tick at that edge is ignored.
- R11: Reset clears the offset, the toggle bit and both flags, and seeds the LFSR to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Modulation enable |
| prbs_sel | input | 1 | Qualify ticks by the pseudo-random bit |
| amp | input | 4 | Amplitude field; 0 selects LSB toggling |
| step | input | 4 | Step-size field; 0 and 1 both give a step of 1 |
| fine_in | input | 10 | Unmodulated fine-tune word |
| tick | input | 1 | One-cycle dither tick enable |
| flag_clr | input | 1 | Clears the sticky saturation flags |
| fine_out | output | 10 | Modulated, saturated fine-tune word |
| ovf | output | 1 | Sticky flag for saturation at the top of the range |
| udf | output | 1 | Sticky flag for saturation at the bottom of the range |

## Verification
The bench builds the block with its defaults:

- a 10-bit fine word;
- 4-bit amplitude and step fields;
- the 15-bit LFSR.

With these widths, a peak offset of ±3 is enough to saturate at both 1023 and 0, so both flags are reached in a few ticks. The LFSR starts from a known seed right after reset. Its first run of zero bits therefore gates ticks within the first twenty ticks. Amplitudes of 1 and 2, with steps of 0, 1 and 3, cover the turning points of the triangle and the treatment of a zero step.

// File: rtl/ssg_pkg.sv
package ssg_pkg;

    localparam int PRBS_W = 15;
    localparam logic [PRBS_W-1:0] PRBS_SEED = 15'h0001;

    typedef enum logic {
        DIR_UP = 1'b0,
        DIR_DN = 1'b1
    } ssg_dir_e;

    typedef struct packed {
        logic hi;
        logic lo;
    } ssg_sat_t;

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/ssg_prbs.sv
module ssg_prbs
    import ssg_pkg::*;
#(
    parameter int W = PRBS_W,
    parameter logic [W-1:0] SEED = PRBS_SEED
) (
    input  logic clk,
    input  logic rst,
    input  logic adv,
    output logic bit_o
);
    localparam int TAP_A = W - 1;
    localparam int TAP_B = W - 2;

    logic [W-1:0] sr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q <= SEED;
        end else if (adv) begin
            sr_q <= {sr_q[W-2:0], sr_q[TAP_A] ^ sr_q[TAP_B]};
        end
    end

    assign bit_o = sr_q[0];

endmodule

// File: rtl/ssg_tri.sv
module ssg_tri
    import ssg_pkg::*;
#(
    parameter int AMP_W  = 4,
    parameter int STEP_W = 4,
    parameter int OFF_W  = AMP_W + STEP_W + 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     hold_zero,
    input  logic                     adv,
    input  logic [AMP_W-1:0]         amp,
    input  logic [STEP_W-1:0]        step,
    output logic signed [OFF_W-1:0]  off,
    output logic                     tog
);
    localparam int PW = AMP_W + STEP_W;

    logic [STEP_W-1:0]        step_eff;
    logic [PW-1:0]            amp_x;
    logic [PW-1:0]            step_x;
    logic [PW-1:0]            lim_u;
    logic signed [OFF_W-1:0]  lim_s;
    logic signed [OFF_W-1:0]  step_s;
    logic signed [OFF_W-1:0]  nxt_up;
    logic signed [OFF_W-1:0]  nxt_dn;
    ssg_dir_e                 dir_q;

    always_comb begin
        step_eff = (step < STEP_W'(2)) ? STEP_W'(1) : step;
        amp_x    = PW'(amp);
        step_x   = PW'(step_eff);
        lim_u    = amp_x * step_x;
        lim_s    = signed'({1'b0, lim_u});
        step_s   = signed'(OFF_W'(step_eff));
        nxt_up   = off + step_s;
        nxt_dn   = off - step_s;
    end

    always_ff @(posedge clk) begin
        if (rst || hold_zero) begin
            off   <= '0;
            dir_q <= DIR_UP;
            tog   <= 1'b0;
        end else if (adv) begin
            if (amp == '0) begin
                tog <= ~tog;
            end else if (dir_q == DIR_UP) begin
                off <= nxt_up;
                if (nxt_up >= lim_s) dir_q <= DIR_DN;
            end else begin
                off <= nxt_dn;
                if (nxt_dn <= -lim_s) dir_q <= DIR_UP;
            end
        end
    end

endmodule

// File: rtl/ssg_sat.sv
module ssg_sat
    import ssg_pkg::*;
#(
    parameter int FINE_W = 10,
    parameter int OFF_W  = 9
) (
    input  logic [FINE_W-1:0]        fine,
    input  logic signed [OFF_W-1:0]  off,
    output logic [FINE_W-1:0]        sum,
    output ssg_sat_t                 sat
);
    localparam int SUM_W = max_int(FINE_W, OFF_W) + 2;
    localparam logic signed [SUM_W-1:0] TOP = signed'(SUM_W'({FINE_W{1'b1}}));

    logic signed [SUM_W-1:0] raw;

    always_comb begin
        raw    = signed'(SUM_W'(fine)) + SUM_W'(off);
        sat.hi = (raw > TOP);
        sat.lo = (raw < 0);
        if (sat.hi)      sum = {FINE_W{1'b1}};
        else if (sat.lo) sum = '0;
        else             sum = raw[FINE_W-1:0];
    end

endmodule

// File: rtl/ssg_fine_mod.sv
module ssg_fine_mod
    import ssg_pkg::*;
#(
    parameter int FINE_W = 10,
    parameter int AMP_W  = 4,
    parameter int STEP_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              prbs_sel,
    input  logic [AMP_W-1:0]  amp,
    input  logic [STEP_W-1:0] step,
    input  logic [FINE_W-1:0] fine_in,
    input  logic              tick,
    input  logic              flag_clr,
    output logic [FINE_W-1:0] fine_out,
    output logic              ovf,
    output logic              udf
);
    localparam int OFF_W = AMP_W + STEP_W + 1;

    logic [AMP_W-1:0]         amp_q;
    logic [STEP_W-1:0]        step_q;
    logic                     cfg_chg;
    logic                     hold_zero;
    logic                     prbs_bit;
    logic                     qtick;
    logic signed [OFF_W-1:0]  offset;
    logic                     tog;
    logic [FINE_W-1:0]        sat_sum;
    ssg_sat_t                 sat;
    logic                     tri_mode;

    always_ff @(posedge clk) begin
        if (rst) begin
            amp_q  <= '0;
            step_q <= '0;
        end else begin
            amp_q  <= amp;
            step_q <= step;
        end
    end

    assign cfg_chg   = (amp != amp_q) || (step != step_q);
    assign hold_zero = !en || cfg_chg;
    assign qtick     = tick && (!prbs_sel || prbs_bit);
    assign tri_mode  = (amp != '0);

    ssg_prbs #(.W(PRBS_W), .SEED(PRBS_SEED)) u_prbs (
        .clk   (clk),
        .rst   (rst),
        .adv   (tick),
        .bit_o (prbs_bit)
    );

    ssg_tri #(.AMP_W(AMP_W), .STEP_W(STEP_W), .OFF_W(OFF_W)) u_tri (
        .clk       (clk),
        .rst       (rst),
        .hold_zero (hold_zero),
        .adv       (qtick),
        .amp       (amp),
        .step      (step),
        .off       (offset),
        .tog       (tog)
    );

    ssg_sat #(.FINE_W(FINE_W), .OFF_W(OFF_W)) u_sat (
        .fine (fine_in),
        .off  (offset),
        .sum  (sat_sum),
        .sat  (sat)
    );

    always_comb begin
        if (!en)           fine_out = fine_in;
        else if (tri_mode) fine_out = sat_sum;
        else               fine_out = fine_in ^ FINE_W'(tog);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ovf <= 1'b0;
            udf <= 1'b0;
        end else begin
            ovf <= (ovf && !flag_clr) || (en && tri_mode && sat.hi);
            udf <= (udf && !flag_clr) || (en && tri_mode && sat.lo);
        end
    end

endmodule

// File: rtl/ssg_fine_mod_chk.sv
module ssg_fine_mod_chk #(
    parameter int FINE_W = 10,
    parameter int AMP_W  = 4,
    parameter int STEP_W = 4,
    parameter int OFF_W  = AMP_W + STEP_W + 1
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     en,
    input logic [AMP_W-1:0]         amp,
    input logic [STEP_W-1:0]        step,
    input logic                     tick,
    input logic                     flag_clr,
    input logic [FINE_W-1:0]        fine_out,
    input logic                     ovf,
    input logic                     udf,
    input logic signed [OFF_W-1:0]  off
);
    localparam int PW = AMP_W + STEP_W;

    logic [PW-1:0]           lim_u;
    logic signed [OFF_W-1:0] lim_s;

    always_comb begin
        lim_u = PW'(amp) * PW'((step < STEP_W'(2)) ? STEP_W'(1) : step);
        lim_s = signed'({1'b0, lim_u});
    end

    // R1: a cleared enable returns the offset to zero
    p_off_zero_r1: assert property (@(posedge clk) disable iff (rst)
        !en |=> off == '0);

    // R2: without a tick, the offset is either held or forced to zero
    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !tick |=> (off == '0 || $stable(off)));

    // R5: under a steady configuration, the offset stays within the peak
    p_bound_r5: assert property (@(posedge clk) disable iff (rst)
        ($stable(amp) && $stable(step)) |-> (off <= lim_s && off >= -lim_s));

    // R7: the high flag rises only after the output sat at the top
    p_ovf_src_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf) |-> ($past(en) && $past(fine_out) == {FINE_W{1'b1}}));

    // R8: the low flag rises only after the output sat at zero
    p_udf_src_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(udf) |-> ($past(en) && $past(fine_out) == '0));

    // R9: a clear with no saturation present drops the high flag
    p_clr_r9: assert property (@(posedge clk) disable iff (rst)
        (flag_clr && fine_out != {FINE_W{1'b1}}) |=> !ovf);

    // R10: a change of amplitude or step zeroes the offset
    p_cfg_r10: assert property (@(posedge clk) disable iff (rst)
        (!$stable(amp) || !$stable(step)) |=> off == '0);

endmodule

bind ssg_fine_mod ssg_fine_mod_chk #(
    .FINE_W(FINE_W), .AMP_W(AMP_W), .STEP_W(STEP_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .amp      (amp),
    .step     (step),
    .tick     (tick),
    .flag_clr (flag_clr),
    .fine_out (fine_out),
    .ovf      (ovf),
    .udf      (udf),
    .off      (offset)
);

// File: tb/sim_ssg_fine_mod.sv
module sim_ssg_fine_mod;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en = 1'b0;
    logic       prbs_sel = 1'b0;
    logic [3:0] amp = '0;
    logic [3:0] step = '0;
    logic [9:0] fine_in = '0;
    logic       tick = 1'b0;
    logic       flag_clr = 1'b0;
    logic [9:0] fine_out;
    logic       ovf;
    logic       udf;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    ssg_fine_mod u0 (
        .clk(clk), .rst(rst), .en(en), .prbs_sel(prbs_sel), .amp(amp),
        .step(step), .fine_in(fine_in), .tick(tick), .flag_clr(flag_clr),
        .fine_out(fine_out), .ovf(ovf), .udf(udf)
    );

    typedef struct packed {
        logic       en;
        logic [3:0] amp;
        logic [3:0] stp;
        logic [9:0] fine;
        logic       tk;
        logic [9:0] exp;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 32;
    localparam vec_t TBL [NV] = '{
        '{1'b0, 4'd0, 4'd0, 10'd300, 1'b0, 10'd300, 4'd1},  // R1
        '{1'b0, 4'd0, 4'd0, 10'd300, 1'b1, 10'd300, 4'd1},  // R1 tick ignored
        '{1'b1, 4'd0, 4'd0, 10'd300, 1'b0, 10'd300, 4'd4},  // R4
        '{1'b1, 4'd0, 4'd0, 10'd300, 1'b1, 10'd301, 4'd4},
        '{1'b1, 4'd0, 4'd0, 10'd300, 1'b1, 10'd300, 4'd4},
        '{1'b1, 4'd0, 4'd0, 10'd300, 1'b0, 10'd300, 4'd2},  // R2
        '{1'b1, 4'd0, 4'd0, 10'd301, 1'b1, 10'd300, 4'd4},
        '{1'b1, 4'd1, 4'd1, 10'd500, 1'b0, 10'd500, 4'd10}, // R10
        '{1'b1, 4'd1, 4'd1, 10'd500, 1'b1, 10'd501, 4'd5},  // R5
        '{1'b1, 4'd1, 4'd1, 10'd500, 1'b1, 10'd500, 4'd5},
        '{1'b1, 4'd1, 4'd1, 10'd500, 1'b1, 10'd499, 4'd5},
        '{1'b1, 4'd1, 4'd1, 10'd500, 1'b0, 10'd499, 4'd2},  // R2
        '{1'b1, 4'd1, 4'd1, 10'd500, 1'b1, 10'd500, 4'd5},
        '{1'b1, 4'd1, 4'd1, 10'd500, 1'b1, 10'd501, 4'd5},
        '{1'b1, 4'd2, 4'd0, 10'd500, 1'b1, 10'd500, 4'd10}, // R10 tick dropped
        '{1'b1, 4'd2, 4'd0, 10'd500, 1'b1, 10'd501, 4'd6},  // R6
        '{1'b1, 4'd2, 4'd0, 10'd500, 1'b1, 10'd502, 4'd6},
        '{1'b1, 4'd2, 4'd0, 10'd500, 1'b1, 10'd501, 4'd6},
        '{1'b1, 4'd2, 4'd0, 10'd500, 1'b1, 10'd500, 4'd6},
        '{1'b1, 4'd2, 4'd0, 10'd500, 1'b1, 10'd499, 4'd6},
        '{1'b1, 4'd2, 4'd0, 10'd500, 1'b1, 10'd498, 4'd6},
        '{1'b1, 4'd2, 4'd0, 10'd500, 1'b1, 10'd499, 4'd6},
        '{1'b1, 4'd2, 4'd3, 10'd500, 1'b0, 10'd500, 4'd10}, // R10
        '{1'b1, 4'd2, 4'd3, 10'd500, 1'b1, 10'd503, 4'd5},
        '{1'b1, 4'd2, 4'd3, 10'd500, 1'b1, 10'd506, 4'd5},
        '{1'b1, 4'd2, 4'd3, 10'd500, 1'b1, 10'd503, 4'd5},
        '{1'b1, 4'd2, 4'd3, 10'd500, 1'b1, 10'd500, 4'd5},
        '{1'b1, 4'd2, 4'd3, 10'd500, 1'b1, 10'd497, 4'd5},
        '{1'b1, 4'd2, 4'd3, 10'd500, 1'b1, 10'd494, 4'd5},
        '{1'b1, 4'd2, 4'd3, 10'd500, 1'b1, 10'd497, 4'd5},
        '{1'b0, 4'd2, 4'd3, 10'd500, 1'b1, 10'd500, 4'd1},  // R1 disable
        '{1'b1, 4'd2, 4'd3, 10'd500, 1'b1, 10'd503, 4'd1}   // R1 restarts at zero
    };

    task automatic chk(input string req, input logic [9:0] act, input logic [9:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc(input logic e, input logic [3:0] a, input logic [3:0] s,
                       input logic [9:0] f, input logic t, input logic c);
        @(negedge clk);
        en = e; amp = a; step = s; fine_in = f; tick = t; flag_clr = c;
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; en = 1'b0; prbs_sel = 1'b0; amp = '0; step = '0;
        tick = 1'b0; flag_clr = 1'b0; fine_in = 10'd77;
        @(posedge clk);
        @(posedge clk);
        #1;
        chk("R11", fine_out, 10'd77);
        chk("R11", {9'd0, ovf}, 10'd0);
        chk("R11", {9'd0, udf}, 10'd0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #1600000;
        errors++;
        $display("FAIL watchdog actual hung expected done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        do_reset();

        for (int i = 0; i < NV; i++) begin
            cyc(TBL[i].en, TBL[i].amp, TBL[i].stp, TBL[i].fine, TBL[i].tk, 1'b0);
            chk($sformatf("R%0d vec%0d", TBL[i].req, i), fine_out, TBL[i].exp);
        end

        // R7: overflow saturation and sticky flag
        cyc(1'b0, 4'd3, 4'd1, 10'd1022, 1'b0, 1'b0);
        cyc(1'b1, 4'd3, 4'd1, 10'd1022, 1'b0, 1'b0);
        cyc(1'b1, 4'd3, 4'd1, 10'd1022, 1'b1, 1'b0);
        chk("R7", fine_out, 10'd1023);
        chk("R7", {9'd0, ovf}, 10'd0);
        cyc(1'b1, 4'd3, 4'd1, 10'd1022, 1'b1, 1'b0);
        chk("R7", fine_out, 10'd1023);
        cyc(1'b1, 4'd3, 4'd1, 10'd1022, 1'b0, 1'b0);
        chk("R7", {9'd0, ovf}, 10'd1);
        cyc(1'b1, 4'd3, 4'd1, 10'd500, 1'b0, 1'b0);
        chk("R7 sticky", {9'd0, ovf}, 10'd1);
        // R9: clear when nothing saturates
        cyc(1'b1, 4'd3, 4'd1, 10'd500, 1'b0, 1'b1);
        chk("R9", {9'd0, ovf}, 10'd0);
        // R9: clear with saturation present keeps the flag
        cyc(1'b1, 4'd3, 4'd1, 10'd1022, 1'b0, 1'b1);
        chk("R9 set wins", {9'd0, ovf}, 10'd1);
        cyc(1'b1, 4'd3, 4'd1, 10'd500, 1'b0, 1'b1);
        chk("R9", {9'd0, ovf}, 10'd0);

        // R8: underflow saturation
        cyc(1'b0, 4'd3, 4'd1, 10'd1, 1'b0, 1'b0);
        cyc(1'b1, 4'd3, 4'd1, 10'd1, 1'b0, 1'b0);
        for (int k = 0; k < 7; k++) cyc(1'b1, 4'd3, 4'd1, 10'd1, 1'b1, 1'b0);
        chk("R8", fine_out, 10'd0);
        chk("R8", {9'd0, udf}, 10'd0);
        cyc(1'b1, 4'd3, 4'd1, 10'd1, 1'b1, 1'b0);
        chk("R8", fine_out, 10'd0);
        cyc(1'b1, 4'd3, 4'd1, 10'd1, 1'b0, 1'b0);
        chk("R8", {9'd0, udf}, 10'd1);
        chk("R8 no ovf", {9'd0, ovf}, 10'd0);

        // R3: pseudo-random gating of ticks in toggle mode
        do_reset();
        prbs_sel = 1'b1;
        cyc(1'b1, 4'd0, 4'd0, 10'd100, 1'b0, 1'b0);
        begin
            logic [14:0] lf;
            logic        tg;
            lf = 15'h0001;
            tg = 1'b0;
            for (int k = 0; k < 24; k++) begin
                if (lf[0]) tg = ~tg;
                lf = {lf[13:0], lf[14] ^ lf[13]};
                cyc(1'b1, 4'd0, 4'd0, 10'd100, 1'b1, 1'b0);
                chk($sformatf("R3 tick%0d", k), fine_out, 10'd100 ^ {9'd0, tg});
            end
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule